// File: doc/BRIEF.md
# Glitch-Rejecting Counter Read Filter

This block sits between a free-running 64-bit system counter and a register-read path. While a higher counter bit rolls over, the counter's low bits can briefly settle on a wrong value. That value can make time appear to jump backward, as in ...7ff, then ...000, then ...800. It can also make time appear to jump forward, as in ...7ff, then ...fff, then ...800. A bad sample of this kind always shows one of two patterns in its bottom ten bits: all ones or all zeros. The filter rejects any sample with either pattern.

When the filter accepts a request, it samples the counter once per clock. It delivers the first sample whose bottom ten bits are neither all ones nor all zeros. Most samples pass on the first try, so most reads finish one cycle after the request. A parameter sets the retry budget. If every sample up to that budget is rejected, the filter returns the last sample anyway and raises a sticky timeout flag. A dedicated input clears the flag.

While a read is in progress the filter drops its ready output, and any request in that time is ignored.

Top module: `ctr_read_filter`

## Requirements
- R1: A request taken while `rd_ready_o` is 1 samples `cnt_i` in the same cycle. If that sample is acceptable, `rd_valid_o` is 1 in the next cycle, with `rd_data_o` equal to that sample.
- R2: A sample is rejected when bits [9:0] are all ones (0x3FF) or all zeros (0x000). Equivalently, it is rejected when (value+1) mod 1024 is at most 1. A new sample is taken every clock, and the first acceptable sample is the one delivered. The low-field values 0x001 and 0x3FE are acceptable.
- R3: A read takes at most BUDGET samples (default 150). If every sample is rejected, `rd_valid_o` rises BUDGET cycles after the request cycle.
- R4: When the budget runs out, the last rejected sample is delivered and `tmo_flag_o` becomes 1 together with `rd_valid_o`.
- R5: `rd_ready_o` is 0 from the cycle after a rejected first sample until the cycle after delivery. Requests in that time start no further read.
- R6: `tmo_flag_o` stays 1 across later successful reads until `tmo_clr_i` is held high at a clock edge. If a timeout occurs at the same edge, setting wins over clearing.
- R7: `rd_valid_o` is high for exactly one cycle per delivery. `rd_data_o` holds its value between deliveries.
- R8: After reset, `rd_ready_o`=1, `rd_valid_o`=0, `rd_data_o`=0 and `tmo_flag_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_i | input | 1 | Read request, taken when `rd_ready_o` is 1 |
| rd_ready_o | output | 1 | Filter idle and able to take a request |
| cnt_i | input | 64 | Free-running counter value |
| rd_valid_o | output | 1 | One-cycle strobe marking a delivered value |
| rd_data_o | output | 64 | Delivered counter value, held between deliveries |
| tmo_flag_o | output | 1 | Sticky flag: a read exhausted its retry budget |
| tmo_clr_i | input | 1 | Clears the timeout flag |

## Verification
The first group of tests uses samples with clean low fields, including the edge values 0x001 and 0x3FE. These show that only the two rollover patterns are filtered, and that the comparison is not off by one. Other tests start a read with an all-ones or all-zeros low field and follow it with a clean value. These show that each pattern is rejected on its own, and that the delivered value is the later sample rather than the first. A counter held at ...7FF for the whole read measures the budget length exactly, and also checks the fallback value and the flag. Requests pulsed during a long read, followed by a clear pulse, separate the single-delivery behaviour and the sticky-flag behaviour from a block that would restart or clear on its own.

// File: rtl/ctr_read_filter_pkg.sv
package ctr_read_filter_pkg;

    typedef enum logic {
        RF_IDLE = 1'b0,
        RF_WAIT = 1'b1
    } rf_state_e;

endpackage

// File: rtl/ctr_sample_check.sv
module ctr_sample_check #(
    parameter int CNT_W = 64,
    parameter int LOW_W = 10
) (
    input  logic [CNT_W-1:0] sample_i,
    output logic             usable_o
);
    localparam logic [LOW_W-1:0] LOW_ONES  = '1;
    localparam logic [LOW_W-1:0] LOW_ZEROS = '0;

    logic [LOW_W-1:0] low_field;

    always_comb begin
        low_field = sample_i[LOW_W-1:0];
        usable_o  = (low_field != LOW_ONES) && (low_field != LOW_ZEROS);
    end
endmodule

// File: rtl/ctr_sticky_flag.sv
module ctr_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/ctr_read_filter.sv
module ctr_read_filter
    import ctr_read_filter_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int LOW_W  = 10,
    parameter int BUDGET = 150
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req_i,
    output logic             rd_ready_o,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             rd_valid_o,
    output logic [CNT_W-1:0] rd_data_o,
    output logic             tmo_flag_o,
    input  logic             tmo_clr_i
);
    localparam int BUD_W = $clog2(BUDGET + 1);
    localparam logic [BUD_W-1:0] BUD_FULL = BUD_W'(BUDGET);
    localparam logic [BUD_W-1:0] BUD_LAST = BUD_W'(1);

    typedef struct packed {
        rf_state_e        state;
        logic [BUD_W-1:0] left;
        logic [CNT_W-1:0] data;
        logic             valid;
    } rf_regs_t;

    rf_regs_t r_d, r_q;

    logic             usable;
    logic             take_sample;
    logic [BUD_W-1:0] left_now;
    logic             tmo_set;

    ctr_sample_check #(
        .CNT_W (CNT_W),
        .LOW_W (LOW_W)
    ) i_check (
        .sample_i (cnt_i),
        .usable_o (usable)
    );

    always_comb begin
        r_d         = r_q;
        r_d.valid   = 1'b0;
        tmo_set     = 1'b0;
        take_sample = (r_q.state == RF_WAIT) || rd_req_i;
        left_now    = (r_q.state == RF_IDLE) ? BUD_FULL : r_q.left;

        if (take_sample) begin
            if (usable || (left_now <= BUD_LAST)) begin
                r_d.data  = cnt_i;
                r_d.valid = 1'b1;
                r_d.state = RF_IDLE;
                r_d.left  = '0;
                tmo_set   = !usable;
            end else begin
                r_d.state = RF_WAIT;
                r_d.left  = left_now - BUD_LAST;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= RF_IDLE;
            r_q.left  <= '0;
            r_q.data  <= '0;
            r_q.valid <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    ctr_sticky_flag i_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (tmo_set),
        .clr_i  (tmo_clr_i),
        .flag_o (tmo_flag_o)
    );

    assign rd_ready_o = (r_q.state == RF_IDLE);
    assign rd_valid_o = r_q.valid;
    assign rd_data_o  = r_q.data;
endmodule

// File: rtl/ctr_read_filter_chk.sv
module ctr_read_filter_chk #(
    parameter int CNT_W  = 64,
    parameter int LOW_W  = 10,
    parameter int BUDGET = 150
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req_i,
    input logic             rd_ready_o,
    input logic [CNT_W-1:0] cnt_i,
    input logic             rd_valid_o,
    input logic [CNT_W-1:0] rd_data_o,
    input logic             tmo_flag_o,
    input logic             tmo_clr_i
);
    localparam int RUN_W = $clog2(BUDGET + 1) + 1;
    localparam logic [LOW_W-1:0] ONES = '1;

    logic [RUN_W-1:0] busy_run_q;
    logic             cnt_clean;
    logic             data_clean;

    assign cnt_clean  = (cnt_i[LOW_W-1:0] != ONES) && (cnt_i[LOW_W-1:0] != '0);
    assign data_clean = (rd_data_o[LOW_W-1:0] != ONES) && (rd_data_o[LOW_W-1:0] != '0);

    always_ff @(posedge clk) begin
        if (!rst_n)           busy_run_q <= '0;
        else if (rd_ready_o)  busy_run_q <= '0;
        else                  busy_run_q <= busy_run_q + 1'b1;
    end

    AST_FIRST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready_o && rd_req_i && cnt_clean |=> rd_valid_o && (rd_data_o == $past(cnt_i))); // R1
    AST_CLEAN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && !tmo_flag_o |-> data_clean); // R2
    AST_BUDGET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run_q < RUN_W'(BUDGET)); // R3
    AST_TMO_ON_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag_o) |-> rd_valid_o && !data_clean); // R4
    AST_NO_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ready_o |-> !rd_valid_o); // R5
    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_flag_o && !tmo_clr_i |=> tmo_flag_o); // R6
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_o |-> $stable(rd_data_o)); // R7
endmodule

bind ctr_read_filter ctr_read_filter_chk #(
    .CNT_W  (CNT_W),
    .LOW_W  (LOW_W),
    .BUDGET (BUDGET)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req_i   (rd_req_i),
    .rd_ready_o (rd_ready_o),
    .cnt_i      (cnt_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .tmo_flag_o (tmo_flag_o),
    .tmo_clr_i  (tmo_clr_i)
);

// File: tb/test_ctr_read_filter.sv
module test_ctr_read_filter;
    localparam int CLK_PERIOD = 10;
    localparam int BUDGET     = 150;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req_i = 1'b0;
    logic        rd_ready_o;
    logic [63:0] cnt_i = '0;
    logic        rd_valid_o;
    logic [63:0] rd_data_o;
    logic        tmo_flag_o;
    logic        tmo_clr_i = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctr_read_filter #(.CNT_W(64), .LOW_W(10), .BUDGET(BUDGET)) i_ctr_read_filter (
        .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req_i), .rd_ready_o(rd_ready_o),
        .cnt_i(cnt_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .tmo_flag_o(tmo_flag_o), .tmo_clr_i(tmo_clr_i)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic t_reset;
        check(rd_ready_o == 1'b1, "R8 ready", 64'(rd_ready_o), 64'd1);
        check(rd_valid_o == 1'b0, "R8 valid", 64'(rd_valid_o), 64'd0);
        check(rd_data_o == 64'd0, "R8 data", rd_data_o, 64'd0);
        check(tmo_flag_o == 1'b0, "R8 flag", 64'(tmo_flag_o), 64'd0);
    endtask

    // R1: one clean sample delivered one cycle after the request
    task automatic t_clean(input logic [63:0] v, input string tag);
        @(negedge clk); rd_req_i = 1'b1; cnt_i = v;
        tick;
        rd_req_i = 1'b0;
        check(rd_valid_o == 1'b1, tag, 64'(rd_valid_o), 64'd1);
        check(rd_data_o == v, tag, rd_data_o, v);
        tick;
        check(rd_valid_o == 1'b0, "R7 valid single pulse", 64'(rd_valid_o), 64'd0);
        check(rd_data_o == v, "R7 data held", rd_data_o, v);
    endtask

    // R2/R5: bad first sample, then a clean one is delivered
    task automatic t_reject(input logic [63:0] bad, input logic [63:0] good, input string tag);
        @(negedge clk); rd_req_i = 1'b1; cnt_i = bad;
        tick;
        rd_req_i = 1'b0;
        check(rd_valid_o == 1'b0, tag, 64'(rd_valid_o), 64'd0);
        check(rd_ready_o == 1'b0, "R5 ready low while busy", 64'(rd_ready_o), 64'd0);
        @(negedge clk); cnt_i = good;
        tick;
        check(rd_valid_o == 1'b1, tag, 64'(rd_valid_o), 64'd1);
        check(rd_data_o == good, tag, rd_data_o, good);
        check(rd_ready_o == 1'b1, "R5 ready back", 64'(rd_ready_o), 64'd1);
    endtask

    // R5: requests during a read start nothing extra
    task automatic t_busy_req;
        int pulses = 0;
        @(negedge clk); rd_req_i = 1'b1; cnt_i = 64'h55_0000_0000;
        tick;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); rd_req_i = 1'b1; cnt_i = 64'h55_0000_0000;
            tick;
            if (rd_valid_o) pulses++;
        end
        @(negedge clk); rd_req_i = 1'b0; cnt_i = 64'h55_0000_0042;
        tick;
        if (rd_valid_o) pulses++;
        check(rd_data_o == 64'h55_0000_0042, "R5 busy data", rd_data_o, 64'h55_0000_0042);
        for (int i = 0; i < 4; i++) begin
            tick;
            if (rd_valid_o) pulses++;
        end
        check(pulses == 1, "R5 one delivery only", 64'(pulses), 64'd1);
    endtask

    // R3/R4: budget exhausted
    task automatic t_timeout;
        int cyc;
        @(negedge clk); rd_req_i = 1'b1; cnt_i = 64'hABC_7FF;
        tick;
        rd_req_i = 1'b0;
        cyc = 1;
        while (!rd_valid_o && cyc < 4 * BUDGET) begin
            tick;
            cyc++;
        end
        check(cyc == BUDGET, "R3 budget length", 64'(cyc), 64'(BUDGET));
        check(rd_data_o == 64'hABC_7FF, "R4 last sample returned", rd_data_o, 64'hABC_7FF);
        check(tmo_flag_o == 1'b1, "R4 timeout flag set", 64'(tmo_flag_o), 64'd1);
    endtask

    // R6: sticky flag and clear
    task automatic t_sticky;
        t_clean(64'h1_0000_0200, "R6 clean read after timeout");
        check(tmo_flag_o == 1'b1, "R6 flag sticky", 64'(tmo_flag_o), 64'd1);
        @(negedge clk); tmo_clr_i = 1'b1;
        tick;
        tmo_clr_i = 1'b0;
        check(tmo_flag_o == 1'b0, "R6 flag cleared", 64'(tmo_flag_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        t_reset;
        t_clean(64'h0123_4567_89AB_C123, "R1 clean first sample");
        t_clean(64'hFFFF_0000_0000_0001, "R2 low 0x001 accepted");
        t_clean(64'h0000_0000_0000_03FE, "R2 low 0x3FE accepted");
        t_reject(64'h0000_0012_3456_7BFF, 64'h0000_0012_3456_7C00 + 64'd5, "R2 all-ones rejected");
        t_reject(64'h0000_0099_0000_0400, 64'h0000_0099_0000_0401, "R2 all-zeros rejected");
        t_busy_req;
        t_timeout;
        t_sticky;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule